// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This unit sits beside the fetch stage of a small 16-bit processor core. It watches the pending exception sources: the first clock after reset release, a trace trap, a fast and a normal active-low interrupt line (each gated by its own enable), and software interrupts offered on a valid/ready channel together with a vector offset. It also watches a break request, which overrides every one of these sources. When the unit is idle and no break request is present, it picks the winning source by a fixed priority.

After picking a source, the unit reads that source's 16-bit handler word from program memory through a one-cycle read port. It then presents a 22-bit jump target, which is the word with zeros placed above it, as a one-cycle redirect pulse. At the moment of arbitration it copies the current PC into the save register that belongs to the winning source. When the redirect is for reset, it also asks for the status register to be loaded with its power-on value.

The software-interrupt channel follows the valid/ready rule. An offer is accepted on a clock edge where `swi_valid` and `swi_ready` are both high. `swi_ready` stays low from the edge that accepts an offer until the edge where that interrupt wins arbitration. While `swi_ready` is low, the offer is neither taken nor stored.

Top module: `exc_vector_unit`

## Requirements
- R1: The vector word addresses are 0x000000 for reset, 0x000002 for the fast interrupt, 0x000004 for the normal interrupt and 0x000006 for the trace trap. A software interrupt uses its own offset as the address. `redir_target` equals six zero bits followed by the 16-bit word that program memory returns for that address.
- R2: When several sources are pending, the winner is chosen in this order, highest first: reset, trace trap, fast interrupt, software interrupt, normal interrupt.
- R3: While `brk_req` is high, no arbitration happens. No read is issued and no redirect occurs, and this includes the reset exception.
- R4: A reset exception becomes pending once, when reset is released, and is taken exactly once. Its redirect cycle raises `sr_init`, and `sr_init_value` has only bit 15 (privilege) set.
- R5: The fast interrupt is pending only while `fiq_n` is low and `fiq_en` is high. The normal interrupt is pending only while `irq_n` is low and `irq_en` is high. A masked line never causes a redirect.
- R6: When an exception is granted, `pc_in` is stored in the save register for that source: `spc_fiq` for the fast interrupt, `spc_irq` for the normal interrupt, and `swi_link` for a software interrupt. Reset and the trace trap store nothing.
- R7: The accepted software-interrupt offset has bit 0 forced to zero. A result below 0x08 is raised to 0x08.
- R8: After an offer is accepted, `swi_ready` stays low until that interrupt is granted. Offers made meanwhile are ignored, and the stored offset does not change.
- R9: Arbitration happens at clock edge k. `pm_rd` is high for exactly one cycle, from edge k to edge k+1, while `pm_addr` holds the vector address. `pm_rdata` must be valid at edge k+2. `redir_valid` is high for exactly one cycle, from edge k+2 to edge k+3.
- R10: No new arbitration happens between a grant and the end of its redirect pulse. A source that loses arbitration stays pending and is served in a later round, at the earliest at edge k+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release makes the reset exception pending |
| brk_req | input | 1 | Break request; blocks all arbitration |
| trace_req | input | 1 | Trace trap request (status trace bit) |
| fiq_n | input | 1 | Fast interrupt line, active low |
| fiq_en | input | 1 | Fast interrupt enable |
| irq_n | input | 1 | Normal interrupt line, active low |
| irq_en | input | 1 | Normal interrupt enable |
| swi_valid | input | 1 | Software interrupt offer |
| swi_ready | output | 1 | Software interrupt slot free |
| swi_offset | input | 8 | Software interrupt vector offset |
| pc_in | input | 22 | Current PC |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 22 | Vector word address |
| pm_rdata | input | 16 | Word returned one cycle after `pm_rd` |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_target | output | 22 | Handler fetch address |
| spc_fiq | output | 22 | PC saved on a fast interrupt |
| spc_irq | output | 22 | PC saved on a normal interrupt |
| swi_link | output | 22 | PC saved on a software interrupt |
| sr_init | output | 1 | Status register load request (reset redirect) |
| sr_init_value | output | 16 | Status register power-on value |

## Verification
When the unit is idle, a source that becomes eligible at the negative edge before edge k shows its read strobe at the next negative-edge sample. Its redirect shows at the third sample. The bench counts these samples from the moment it releases `brk_req`, and it checks the strobe address and the redirect at exactly those points. A source that lost the previous round, and was left pending when the winner was cleared at the redirect sample, is due four samples later. The bench uses this to check that nothing was arbitrated while a fetch was in flight. The save registers and the status request are compared in the redirect sample, because the grant edge has already written them by then.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  typedef enum logic [2:0] {
    EK_NONE, EK_RESET, EK_TRACE, EK_FIQ, EK_SWI, EK_IRQ
  } exc_kind_e;

  typedef enum logic [1:0] {
    FS_IDLE, FS_ISSUE, FS_CAPT, FS_DONE
  } fetch_state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_req,
  input  logic              fiq_n,
  input  logic              fiq_en,
  input  logic              irq_n,
  input  logic              irq_en,
  input  logic              swi_valid,
  input  logic [OFF_W-1:0]  swi_offset,
  output logic              swi_ready,
  input  logic              grant,
  output logic              req_any,
  output exc_kind_e         win_kind,
  output logic [ADDR_W-1:0] win_addr
);
  localparam logic [OFF_W-1:0]  SWI_MIN  = OFF_W'(8);
  localparam logic [ADDR_W-1:0] VEC_RST  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] VEC_FIQ  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] VEC_IRQ  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] VEC_TRC  = ADDR_W'(6);

  logic             rst_pend;
  logic             swi_pend;
  logic [OFF_W-1:0] swi_off_q;
  logic             fiq_act, irq_act;

  function automatic logic [OFF_W-1:0] clamp_off(input logic [OFF_W-1:0] o);
    logic [OFF_W-1:0] e;
    e = {o[OFF_W-1:1], 1'b0};
    if (e < SWI_MIN) e = SWI_MIN;
    return e;
  endfunction

  assign swi_ready = !swi_pend;
  assign fiq_act   = !fiq_n && fiq_en;
  assign irq_act   = !irq_n && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend  <= 1'b1;
      swi_pend  <= 1'b0;
      swi_off_q <= '0;
    end else begin
      if (grant && win_kind == EK_RESET) rst_pend <= 1'b0;
      if (grant && win_kind == EK_SWI) begin
        swi_pend <= 1'b0;
      end else if (swi_valid && swi_ready) begin
        swi_pend  <= 1'b1;
        swi_off_q <= clamp_off(swi_offset);
      end
    end
  end

  always_comb begin
    win_kind = EK_NONE;
    win_addr = '0;
    if (rst_pend) begin
      win_kind = EK_RESET; win_addr = VEC_RST;
    end else if (trace_req) begin
      win_kind = EK_TRACE; win_addr = VEC_TRC;
    end else if (fiq_act) begin
      win_kind = EK_FIQ;   win_addr = VEC_FIQ;
    end else if (swi_pend) begin
      win_kind = EK_SWI;   win_addr = ADDR_W'(swi_off_q);
    end else if (irq_act) begin
      win_kind = EK_IRQ;   win_addr = VEC_IRQ;
    end
  end

  assign req_any = (win_kind != EK_NONE);

  // R8: a held software interrupt keeps its slot and offset until granted
  p_swi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_pend && !(grant && win_kind == EK_SWI)) |=> (swi_pend && $stable(swi_off_q)));

  // R7: stored offset is even and not below the minimum
  p_swi_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swi_pend |-> (!swi_off_q[0] && swi_off_q >= SWI_MIN));

  // R2: a pending reset outranks every other source
  p_rst_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |-> (win_kind == EK_RESET));

  // R5: a masked fast line never wins
  p_fiq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_kind == EK_FIQ) |-> (!fiq_n && fiq_en));
endmodule

// File: rtl/exc_fetch_fsm.sv
module exc_fetch_fsm
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req,
  input  logic              req_any,
  input  exc_kind_e         win_kind,
  input  logic [ADDR_W-1:0] win_addr,
  input  logic [WORD_W-1:0] pm_rdata,
  output logic              grant,
  output logic              pm_rd,
  output logic [ADDR_W-1:0] pm_addr,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_target,
  output exc_kind_e         done_kind
);
  localparam int PAD_W = ADDR_W - WORD_W;

  fetch_state_e      state;
  exc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] target_q;

  assign grant = (state == FS_IDLE) && req_any && !brk_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FS_IDLE;
      kind_q   <= EK_NONE;
      addr_q   <= '0;
      target_q <= '0;
    end else begin
      unique case (state)
        FS_IDLE: if (grant) begin
          kind_q <= win_kind;
          addr_q <= win_addr;
          state  <= FS_ISSUE;
        end
        FS_ISSUE: state <= FS_CAPT;
        FS_CAPT: begin
          target_q <= {{PAD_W{1'b0}}, pm_rdata};
          state    <= FS_DONE;
        end
        FS_DONE: state <= FS_IDLE;
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign pm_rd        = (state == FS_ISSUE);
  assign pm_addr      = addr_q;
  assign redir_valid  = (state == FS_DONE);
  assign redir_target = target_q;
  assign done_kind    = kind_q;

  // R9: read strobe is followed by the redirect two edges later
  p_fetch_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |=> ##1 redir_valid);

  // R9: the redirect pulse lasts one cycle
  p_redir_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);

  // R3: an idle unit with a break request issues no read next cycle
  p_brk_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && state == FS_IDLE) |=> !pm_rd);

  // R1: vector reads stay in the low even word range
  p_vec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |-> (pm_addr[ADDR_W-1:8] == '0 && !pm_addr[0]));

  // R10: no grant while a redirect is on the output
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !grant);
endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int SR_W     = 16,
  parameter int PRIV_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  exc_kind_e         win_kind,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              redir_valid,
  input  exc_kind_e         done_kind,
  output logic [ADDR_W-1:0] spc_fiq,
  output logic [ADDR_W-1:0] spc_irq,
  output logic [ADDR_W-1:0] swi_link,
  output logic              sr_init,
  output logic [SR_W-1:0]   sr_init_value
);
  localparam logic [SR_W-1:0] SR_POR = SR_W'(1) << PRIV_BIT;

  always_ff @(posedge clk) begin
    if (grant) begin
      case (win_kind)
        EK_FIQ:  spc_fiq  <= pc_in;
        EK_IRQ:  spc_irq  <= pc_in;
        EK_SWI:  swi_link <= pc_in;
        default: ;
      endcase
    end
  end

  assign sr_init       = redir_valid && (done_kind == EK_RESET);
  assign sr_init_value = SR_POR;

  // R6: each save register captures the PC seen at its grant
  p_save_fiq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && win_kind == EK_FIQ) |=> (spc_fiq == $past(pc_in)));
  p_save_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && win_kind == EK_IRQ) |=> (spc_irq == $past(pc_in)));
  p_save_swi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && win_kind == EK_SWI) |=> (swi_link == $past(pc_in)));
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int WORD_W   = 16,
  parameter int OFF_W    = 8,
  parameter int SR_W     = 16,
  parameter int PRIV_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req,
  input  logic              trace_req,
  input  logic              fiq_n,
  input  logic              fiq_en,
  input  logic              irq_n,
  input  logic              irq_en,
  input  logic              swi_valid,
  output logic              swi_ready,
  input  logic [OFF_W-1:0]  swi_offset,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              pm_rd,
  output logic [ADDR_W-1:0] pm_addr,
  input  logic [WORD_W-1:0] pm_rdata,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_target,
  output logic [ADDR_W-1:0] spc_fiq,
  output logic [ADDR_W-1:0] spc_irq,
  output logic [ADDR_W-1:0] swi_link,
  output logic              sr_init,
  output logic [SR_W-1:0]   sr_init_value
);
  logic              grant, req_any;
  exc_kind_e         win_kind, done_kind;
  logic [ADDR_W-1:0] win_addr;

  exc_arbiter #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .trace_req(trace_req),
    .fiq_n(fiq_n), .fiq_en(fiq_en), .irq_n(irq_n), .irq_en(irq_en),
    .swi_valid(swi_valid), .swi_offset(swi_offset), .swi_ready(swi_ready),
    .grant(grant), .req_any(req_any), .win_kind(win_kind), .win_addr(win_addr)
  );

  exc_fetch_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .req_any(req_any),
    .win_kind(win_kind), .win_addr(win_addr), .pm_rdata(pm_rdata),
    .grant(grant), .pm_rd(pm_rd), .pm_addr(pm_addr),
    .redir_valid(redir_valid), .redir_target(redir_target), .done_kind(done_kind)
  );

  exc_save_regs #(.ADDR_W(ADDR_W), .SR_W(SR_W), .PRIV_BIT(PRIV_BIT)) u_save (
    .clk(clk), .rst_n(rst_n), .grant(grant), .win_kind(win_kind), .pc_in(pc_in),
    .redir_valid(redir_valid), .done_kind(done_kind),
    .spc_fiq(spc_fiq), .spc_irq(spc_irq), .swi_link(swi_link),
    .sr_init(sr_init), .sr_init_value(sr_init_value)
  );
endmodule

// File: tb/test_exc_vector_unit.sv
module test_exc_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n, brk_req, trace_req, fiq_n, fiq_en, irq_n, irq_en, swi_valid;
  logic        swi_ready, pm_rd, redir_valid, sr_init;
  logic [7:0]  swi_offset;
  logic [21:0] pc_in, pm_addr, redir_target, spc_fiq, spc_irq, swi_link;
  logic [15:0] pm_rdata = '0;
  logic [15:0] sr_init_value;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exc_vector_unit i_exc_vector_unit (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .trace_req(trace_req),
    .fiq_n(fiq_n), .fiq_en(fiq_en), .irq_n(irq_n), .irq_en(irq_en),
    .swi_valid(swi_valid), .swi_ready(swi_ready), .swi_offset(swi_offset),
    .pc_in(pc_in), .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .redir_valid(redir_valid), .redir_target(redir_target),
    .spc_fiq(spc_fiq), .spc_irq(spc_irq), .swi_link(swi_link),
    .sr_init(sr_init), .sr_init_value(sr_init_value)
  );

  function automatic logic [15:0] vec_word(input logic [21:0] a);
    return a[15:0] * 16'h09E5 + 16'h3C1A;
  endfunction

  always @(posedge clk) if (pm_rd) pm_rdata <= vec_word(pm_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_redir(output int lat, output logic [21:0] seen);
    bit found = 0;
    lat = 0;
    seen = '1;
    while (!found && lat < 20) begin
      @(negedge clk);
      lat++;
      if (pm_rd) seen = pm_addr;
      if (redir_valid) found = 1;
    end
    if (!found) lat = 99;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    logic [21:0] seen;
    bit quiet;
    rst_n = 0; brk_req = 1; trace_req = 0; fiq_n = 1; fiq_en = 0;
    irq_n = 1; irq_en = 0; swi_valid = 0; swi_offset = '0; pc_in = '0;
    repeat (3) @(negedge clk);
    check(!redir_valid && !pm_rd, "R9 reset idle", {pm_rd, redir_valid}, 0);
    check(swi_ready, "R8 reset ready", swi_ready, 1);
    rst_n = 1;
    quiet = 1;
    repeat (6) begin
      @(negedge clk);
      if (pm_rd || redir_valid) quiet = 0;
    end
    check(quiet, "R3 break holds reset", quiet, 1);
    brk_req = 0;
    wait_redir(lat, seen);
    check(lat == 3, "R9 reset latency", lat, 3);
    check(seen == 22'h0, "R1 reset vector addr", seen, 0);
    check(redir_target == {6'b0, vec_word(22'h0)}, "R1 reset target",
          redir_target, {6'b0, vec_word(22'h0)});
    check(sr_init && sr_init_value == 16'h8000, "R4 status init",
          {sr_init, sr_init_value}, 32'h18000);
    @(negedge clk);
    check(!redir_valid && !sr_init, "R9 single pulse", redir_valid, 0);
    quiet = 1;
    repeat (8) begin
      @(negedge clk);
      if (pm_rd || redir_valid) quiet = 0;
    end
    check(quiet, "R4 reset taken once", quiet, 1);

    brk_req = 1;
    for (int m = 0; m < 64; m++) begin
      bit pt, pf, ps, pi, first;
      logic [7:0] off, eo;
      logic [21:0] exp_addr, exp_pc;
      int step;
      pt = m[0]; pf = m[1] && m[2]; ps = m[3]; pi = m[4] && m[5];
      off = 8'((m * 37 + 3) & 255);
      eo = {off[7:1], 1'b0};
      if (eo < 8'h08) eo = 8'h08;
      if (ps) begin
        swi_offset = off; swi_valid = 1;
        @(negedge clk);
        check(!swi_ready, "R8 ready low after accept", swi_ready, 0);
        swi_offset = off ^ 8'h40;
        @(negedge clk);
        check(!swi_ready, "R8 second offer refused", swi_ready, 0);
        swi_valid = 0;
      end
      trace_req = m[0]; fiq_n = !m[1]; fiq_en = m[2]; irq_n = !m[4]; irq_en = m[5];
      step = 0;
      exp_pc = 22'(m * 1000 + 5);
      pc_in = exp_pc;
      @(negedge clk);
      brk_req = 0;
      first = 1;
      while (pt || pf || ps || pi) begin
        wait_redir(lat, seen);
        check(lat == (first ? 3 : 4), "R10 round latency", lat, first ? 3 : 4);
        if (pt) begin
          exp_addr = 22'h6;
        end else if (pf) begin
          exp_addr = 22'h2;
          check(spc_fiq == exp_pc, "R6 fast save", spc_fiq, exp_pc);
        end else if (ps) begin
          exp_addr = 22'(eo);
          check(swi_link == exp_pc, "R6 swi save", swi_link, exp_pc);
        end else begin
          exp_addr = 22'h4;
          check(spc_irq == exp_pc, "R6 normal save", spc_irq, exp_pc);
        end
        check(seen == exp_addr, "R2 R7 winner vector", seen, exp_addr);
        check(redir_target == {6'b0, vec_word(exp_addr)}, "R1 target",
              redir_target, {6'b0, vec_word(exp_addr)});
        if (pt) begin pt = 0; trace_req = 0; end
        else if (pf) begin pf = 0; fiq_n = 1; end
        else if (ps) begin ps = 0; end
        else begin pi = 0; irq_n = 1; end
        step++;
        exp_pc = 22'(m * 1000 + step * 7 + 5);
        pc_in = exp_pc;
        first = 0;
      end
      quiet = 1;
      repeat (6) begin
        @(negedge clk);
        if (pm_rd || redir_valid) quiet = 0;
      end
      check(quiet, "R5 masked lines idle", quiet, 1);
      check(swi_ready, "R8 slot freed", swi_ready, 1);
      brk_req = 1; fiq_n = 1; irq_n = 1;
    end
    finish_run();
  end
endmodule